// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block turns edges on general-purpose input pins into latched interrupt requests. It has sixteen interrupt lines. Each line takes one pin position from one of three input ports, and a routing input picks the port for each line. The chosen pin passes through a two-stage synchronizer. The block then compares the synchronized value with the previous sample to find rising and falling edges.

Each line has an interrupt enable bit and two independent polarity bits, one for rising edges and one for falling edges. A qualifying edge latches the line's pending bit. Software can also raise a pending bit through a trigger register. Pending bits drive a small set of interrupt outputs toward an interrupt controller. The five lowest lines each have an output of their own. The next five lines share one output, and the top six lines share another. A separate event-enable register produces one-cycle pulses on a side output and never touches the pending bits.

Software reaches the six registers through a word-addressed read/write port. Reads are combinational. A write takes effect at the next clock edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all six registers read 0, `irq_o` is 0 and `event_o` is 0.
- R2: Word address 0 is the interrupt enable, 1 the event enable, 2 the rising select, 3 the falling select, 4 the software trigger and 5 the pending register. Bit n of each register belongs to line n. Registers 0 to 3 read back the last value written. Addresses 6 and 7 read 0.
- R3: Routing code 0 makes line n follow pin n of port A (`pins_i` bit n). Code 1 follows port B (bit 16+n) and code 2 follows port C (bit 32+n). Code 3 connects no pin, so the line never sees an edge.
- R4: A pin change driven between two clock edges becomes visible in the pending register after the third rising clock edge that follows, and not before.
- R5: A rising edge sets a line's pending bit only when its enable bit and rising-select bit are both 1. A falling edge sets it only when its enable bit and falling-select bit are both 1.
- R6: A line with both select bits set pends on either edge. A line with neither select bit set never pends from a pin.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: Writing 1 to a trigger bit sets that trigger bit. It also sets the line's pending bit at the same edge when the line is enabled, and only then. A trigger bit clears when its pending bit is cleared by a write.
- R9: `irq_o[0]` to `irq_o[4]` follow pending bits 0 to 4 (interrupt numbers 6 to 10). `irq_o[5]` is the OR of pending bits 5 to 9 (number 23). `irq_o[6]` is the OR of pending bits 10 to 15 (number 40). A shared output stays high until every bit of its group is clear.
- R10: `event_o[n]` pulses for exactly one cycle, in the same cycle a pending bit would set, when the line's event enable is 1 and the edge matches a selected polarity. This holds whether or not the line is enabled. The event enable never sets a pending bit.
- R11: When a pending bit is set by an edge in the same cycle that a write clears it, the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 48 | Port A bits 15:0, port B bits 31:16, port C bits 47:32 |
| route_sel_i | input | 32 | Two-bit port code per line, line n at bits 2n+1:2n |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Write enable, qualified by `bus_sel_i` |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for `bus_addr_i` |
| irq_o | output | 7 | Grouped interrupt requests |
| event_o | output | 16 | One-cycle event pulses per line |

## Verification
A pin edge that reaches the compare stage can meet a software write of 1 to the same pending bit in the same cycle. Setting has priority over clearing. The bench times the pin change so that the edge is found in exactly the cycle the clearing write is sampled. It then expects the pending bit to stay set. It also expects the trigger bit to be cleared in that cycle, because that bit follows the write alone. A second clearing write must then drop the bit to show that the first write was honoured.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // Register word indices; the order is fixed by the register map.
   typedef enum logic [2:0] {
      REG_INT_EN    = 3'd0,
      REG_EVT_EN    = 3'd1,
      REG_RISE_EN   = 3'd2,
      REG_FALL_EN   = 3'd3,
      REG_SOFT_TRIG = 3'd4,
      REG_PEND      = 3'd5
   } reg_idx_e;

   localparam int unsigned REG_COUNT = 6;

   // Interrupt output slot that a given line feeds.
   function automatic int unsigned irq_slot(input int unsigned line,
                                            input int unsigned n_single,
                                            input int unsigned mid_last);
      if (line < n_single)       return line;
      else if (line <= mid_last) return n_single;
      else                       return n_single + 1;
   endfunction

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
   input  logic [NUM_LINES*SEL_W-1:0]     sel_i,
   output logic [NUM_LINES-1:0]           rise_o,
   output logic [NUM_LINES-1:0]           fall_o
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("edge_irq_sync: SYNC_STAGES must be at least 2");
   end
   if (NUM_PORTS > (1 << SEL_W)) begin : g_bad_sel
      $error("edge_irq_sync: SEL_W too narrow for NUM_PORTS");
   end

   logic [NUM_LINES-1:0] picked;
   logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
   logic [NUM_LINES-1:0] prev_q;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_route
      logic [SEL_W-1:0] code;
      assign code = sel_i[l*SEL_W +: SEL_W];
      always_comb begin
         picked[l] = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (code == SEL_W'(p)) picked[l] = pins_i[p*NUM_LINES + l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= picked;
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[LAST];
   end

   assign rise_o = stage_q[LAST] & ~prev_q;
   assign fall_o = ~stage_q[LAST] & prev_q;

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
   import edge_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel_i,
   input  logic                 bus_wr_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [NUM_LINES-1:0] bus_wdata_i,
   output logic [NUM_LINES-1:0] bus_rdata_o,
   input  logic [NUM_LINES-1:0] rise_i,
   input  logic [NUM_LINES-1:0] fall_i,
   output logic [NUM_LINES-1:0] int_en_o,
   output logic [NUM_LINES-1:0] evt_en_o,
   output logic [NUM_LINES-1:0] soft_trig_o,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] pend_set_o,
   output logic [NUM_LINES-1:0] pend_clr_o,
   output logic [NUM_LINES-1:0] trig_wr_o,
   output logic [NUM_LINES-1:0] event_o
);

   if ((1 << ADDR_W) < REG_COUNT) begin : g_bad_addr
      $error("edge_irq_regs: ADDR_W cannot reach all registers");
   end

   logic [NUM_LINES-1:0] int_en_q, evt_en_q, rise_en_q, fall_en_q;
   logic [NUM_LINES-1:0] trig_q, pend_q, event_q;
   logic [REG_COUNT-1:0] wr_hit;
   logic [NUM_LINES-1:0] edge_match, trig_wr, pend_set, pend_clr;

   always_comb begin
      for (int r = 0; r < REG_COUNT; r++) begin
         wr_hit[r] = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(r));
      end
   end

   assign edge_match = (rise_i & rise_en_q) | (fall_i & fall_en_q);
   assign trig_wr    = wr_hit[REG_SOFT_TRIG] ? bus_wdata_i : '0;
   assign pend_clr   = wr_hit[REG_PEND]      ? bus_wdata_i : '0;
   assign pend_set   = int_en_q & (edge_match | trig_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en_q  <= '0;
         evt_en_q  <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
         trig_q    <= '0;
         pend_q    <= '0;
         event_q   <= '0;
      end else begin
         if (wr_hit[REG_INT_EN])  int_en_q  <= bus_wdata_i;
         if (wr_hit[REG_EVT_EN])  evt_en_q  <= bus_wdata_i;
         if (wr_hit[REG_RISE_EN]) rise_en_q <= bus_wdata_i;
         if (wr_hit[REG_FALL_EN]) fall_en_q <= bus_wdata_i;
         trig_q  <= (trig_q & ~pend_clr) | trig_wr;
         pend_q  <= (pend_q & ~pend_clr) | pend_set;
         event_q <= evt_en_q & edge_match;
      end
   end

   always_comb begin
      case (bus_addr_i)
         ADDR_W'(REG_INT_EN):    bus_rdata_o = int_en_q;
         ADDR_W'(REG_EVT_EN):    bus_rdata_o = evt_en_q;
         ADDR_W'(REG_RISE_EN):   bus_rdata_o = rise_en_q;
         ADDR_W'(REG_FALL_EN):   bus_rdata_o = fall_en_q;
         ADDR_W'(REG_SOFT_TRIG): bus_rdata_o = trig_q;
         ADDR_W'(REG_PEND):      bus_rdata_o = pend_q;
         default:                bus_rdata_o = '0;
      endcase
   end

   assign int_en_o    = int_en_q;
   assign evt_en_o    = evt_en_q;
   assign soft_trig_o = trig_q;
   assign pend_o      = pend_q;
   assign pend_set_o  = pend_set;
   assign pend_clr_o  = pend_clr;
   assign trig_wr_o   = trig_wr;
   assign event_o     = event_q;

endmodule

// File: rtl/edge_irq_group.sv
module edge_irq_group #(
   parameter int unsigned NUM_LINES    = 16,
   parameter int unsigned SINGLE_LINES = 5,
   parameter int unsigned MID_LAST     = 9
) (
   input  logic [NUM_LINES-1:0]    pend_i,
   output logic [SINGLE_LINES+1:0] irq_o
);

   if (MID_LAST < SINGLE_LINES || MID_LAST + 1 >= NUM_LINES) begin : g_bad_split
      $error("edge_irq_group: shared groups must both be non-empty");
   end

   for (genvar k = 0; k < SINGLE_LINES; k++) begin : g_single
      assign irq_o[k] = pend_i[k];
   end

   assign irq_o[SINGLE_LINES]     = |pend_i[MID_LAST:SINGLE_LINES];
   assign irq_o[SINGLE_LINES + 1] = |pend_i[NUM_LINES-1:MID_LAST+1];

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
   parameter int unsigned NUM_LINES    = 16,
   parameter int unsigned NUM_PORTS    = 3,
   parameter int unsigned SEL_W        = 2,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SINGLE_LINES = 5,
   parameter int unsigned MID_LAST     = 9,
   parameter int unsigned ADDR_W       = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
   input  logic [NUM_LINES*SEL_W-1:0]     route_sel_i,
   input  logic                           bus_sel_i,
   input  logic                           bus_wr_i,
   input  logic [ADDR_W-1:0]              bus_addr_i,
   input  logic [NUM_LINES-1:0]           bus_wdata_i,
   output logic [NUM_LINES-1:0]           bus_rdata_o,
   output logic [SINGLE_LINES+1:0]        irq_o,
   output logic [NUM_LINES-1:0]           event_o
);

   logic [NUM_LINES-1:0] rise, fall;
   logic [NUM_LINES-1:0] int_en, evt_en, soft_trig, pend;
   logic [NUM_LINES-1:0] pend_set, pend_clr, trig_wr;

   edge_irq_sync #(
      .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS),
      .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sel_i(route_sel_i),
      .rise_o(rise), .fall_o(fall)
   );

   edge_irq_regs #(
      .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .rise_i(rise), .fall_i(fall),
      .int_en_o(int_en), .evt_en_o(evt_en), .soft_trig_o(soft_trig),
      .pend_o(pend), .pend_set_o(pend_set), .pend_clr_o(pend_clr),
      .trig_wr_o(trig_wr), .event_o(event_o)
   );

   edge_irq_group #(
      .NUM_LINES(NUM_LINES), .SINGLE_LINES(SINGLE_LINES), .MID_LAST(MID_LAST)
   ) u_group (
      .pend_i(pend), .irq_o(irq_o)
   );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned NUM_IRQ   = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] int_en,
   input logic [NUM_LINES-1:0] evt_en,
   input logic [NUM_LINES-1:0] soft_trig,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] pend_set,
   input logic [NUM_LINES-1:0] pend_clr,
   input logic [NUM_LINES-1:0] trig_wr,
   input logic [NUM_IRQ-1:0]   irq_o,
   input logic [NUM_LINES-1:0] event_o
);

   // R6
   pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(pend_set)) == '0);

   // R5
   pend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ~$past(int_en)) == '0);

   // R7
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & $past(pend_clr & ~pend_set)) == '0);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_set) & ~pend) == '0);

   // R8
   trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_trig & $past(pend_clr & ~trig_wr)) == '0);

   // R9
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|irq_o) |-> $past(pend_clr) != '0);

   // R10
   event_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (event_o & ~$past(evt_en)) == '0);

endmodule

bind edge_irq_ctrl edge_irq_chk #(
   .NUM_LINES(NUM_LINES), .NUM_IRQ(SINGLE_LINES + 2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .int_en(int_en), .evt_en(evt_en),
   .soft_trig(soft_trig), .pend(pend), .pend_set(pend_set),
   .pend_clr(pend_clr), .trig_wr(trig_wr), .irq_o(irq_o), .event_o(event_o)
);

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;

   localparam logic [2:0] A_INT = 3'd0, A_EVT = 3'd1, A_RISE = 3'd2,
                          A_FALL = 3'd3, A_TRIG = 3'd4, A_PEND = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] pins = '0;
   logic [31:0] route = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [6:0]  irq;
   logic [15:0] evt;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   edge_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .route_sel_i(route),
      .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .irq_o(irq), .event_o(evt)
   );

   function automatic logic [6:0] exp_irq(input logic [15:0] p);
      return {|p[15:10], |p[9:5], p[4:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic route_all(input logic [1:0] code);
      for (int i = 0; i < 16; i++) route[i*2 +: 2] = code;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [15:0] bit_l;
      logic [15:0] exp_v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d);
         check("R1 reg reset", 32'(d), 0);
      end
      check("R1 irq reset", 32'(irq), 0);
      check("R1 event reset", 32'(evt), 0);

      // R2: readback and unmapped addresses
      for (int a = 0; a < 4; a++) begin
         wr(3'(a), 16'hA5C3 ^ 16'(a * 16'h1111));
         rd(3'(a), d);
         check("R2 readback", 32'(d), 32'(16'hA5C3 ^ 16'(a * 16'h1111)));
      end
      rd(3'd6, d); check("R2 unmapped 6", 32'(d), 0);
      rd(3'd7, d); check("R2 unmapped 7", 32'(d), 0);
      for (int a = 0; a < 4; a++) wr(3'(a), 16'h0000);

      // R4: latency of the pin path
      route_all(2'd0);
      wr(A_INT, 16'h0001); wr(A_RISE, 16'h0001);
      pins[0] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rd(A_PEND, d); check("R4 not yet after two edges", 32'(d), 0);
      @(posedge clk); @(negedge clk);
      rd(A_PEND, d); check("R4 pending after third edge", 32'(d), 1);
      pins[0] = 1'b0; settle();
      wr(A_PEND, 16'hFFFF);

      // R5/R6: polarity and enable sweep over every port, line and select mode
      for (int p = 0; p < 3; p++) begin
         route_all(2'(p));
         for (int l = 0; l < 16; l++) begin
            for (int m = 0; m < 4; m++) begin
               bit_l = 16'(1) << l;
               wr(A_INT, bit_l);
               wr(A_RISE, (m & 1) != 0 ? bit_l : 16'h0);
               wr(A_FALL, (m & 2) != 0 ? bit_l : 16'h0);
               pins[p*16 + l] = 1'b1;
               settle();
               exp_v = (m & 1) != 0 ? bit_l : 16'h0;
               rd(A_PEND, d);
               check((m == 0 || m == 3) ? "R6 rising" : "R5 rising", 32'(d), 32'(exp_v));
               check("R9 irq on rising", 32'(irq), 32'(exp_irq(exp_v)));
               wr(A_PEND, 16'hFFFF);
               pins[p*16 + l] = 1'b0;
               settle();
               exp_v = (m & 2) != 0 ? bit_l : 16'h0;
               rd(A_PEND, d);
               check((m == 0 || m == 3) ? "R6 falling" : "R5 falling", 32'(d), 32'(exp_v));
               wr(A_PEND, 16'hFFFF);
            end
         end
      end
      wr(A_FALL, 16'h0);

      // R3: routing codes including the unconnected code
      wr(A_INT, 16'hFFFF); wr(A_RISE, 16'hFFFF);
      for (int s = 0; s < 4; s++) begin
         for (int l = 0; l < 16; l++) begin
            route_all(2'd3);
            route[l*2 +: 2] = 2'(s);
            for (int q = 0; q < 3; q++) begin
               pins[q*16 + l] = 1'b1;
               settle();
               rd(A_PEND, d);
               check("R3 routing", 32'(d), (s == q) ? 32'(1) << l : 0);
               pins[q*16 + l] = 1'b0;
               settle();
               wr(A_PEND, 16'hFFFF);
            end
         end
      end

      // R10: event pulses with lines disabled
      route_all(2'd0);
      wr(A_INT, 16'h0);
      for (int l = 0; l < 16; l++) begin
         bit_l = 16'(1) << l;
         wr(A_EVT, bit_l);
         pins[l] = 1'b1;
         settle();
         check("R10 event pulse", 32'(evt), 32'(bit_l));
         rd(A_PEND, d); check("R10 event leaves pending", 32'(d), 0);
         @(negedge clk);
         check("R10 pulse one cycle", 32'(evt), 0);
         pins[l] = 1'b0;
         settle();
         check("R10 unselected edge", 32'(evt), 0);
      end
      wr(A_EVT, 16'h0);

      // R8/R9: software trigger, enabled then disabled
      for (int l = 0; l < 16; l++) begin
         bit_l = 16'(1) << l;
         wr(A_INT, 16'hFFFF);
         wr(A_TRIG, bit_l);
         rd(A_PEND, d); check("R8 trigger pends", 32'(d), 32'(bit_l));
         rd(A_TRIG, d); check("R8 trigger bit set", 32'(d), 32'(bit_l));
         check("R9 irq mapping", 32'(irq), 32'(exp_irq(bit_l)));
         wr(A_PEND, 16'h0);
         rd(A_PEND, d); check("R7 write 0 keeps", 32'(d), 32'(bit_l));
         wr(A_PEND, bit_l);
         rd(A_PEND, d); check("R7 write 1 clears", 32'(d), 0);
         rd(A_TRIG, d); check("R8 trigger cleared", 32'(d), 0);
         wr(A_INT, 16'h0);
         wr(A_TRIG, bit_l);
         rd(A_PEND, d); check("R8 masked trigger", 32'(d), 0);
         rd(A_TRIG, d); check("R8 masked trigger bit", 32'(d), 32'(bit_l));
         wr(A_PEND, bit_l);
         rd(A_TRIG, d); check("R8 masked trigger cleared", 32'(d), 0);
      end

      // R9: shared outputs hold until the whole group is clear
      wr(A_INT, 16'hFFFF);
      wr(A_TRIG, 16'h0220);
      check("R9 mid group", 32'(irq), 32'(7'b0100000));
      wr(A_PEND, 16'h0020);
      check("R9 mid group held", 32'(irq), 32'(7'b0100000));
      wr(A_PEND, 16'h0200);
      check("R9 mid group released", 32'(irq), 0);
      wr(A_TRIG, 16'h8400);
      check("R9 top group", 32'(irq), 32'(7'b1000000));
      wr(A_PEND, 16'h8000);
      check("R9 top group held", 32'(irq), 32'(7'b1000000));
      wr(A_PEND, 16'h0400);
      check("R9 top group released", 32'(irq), 0);

      // R11: edge sets in the same cycle a write clears
      wr(A_RISE, 16'hFFFF);
      wr(A_TRIG, 16'h0008);
      pins[3] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      wr(A_PEND, 16'h0008);
      rd(A_PEND, d); check("R11 set wins", 32'(d), 32'h8);
      rd(A_TRIG, d); check("R11 trigger follows write", 32'(d), 0);
      wr(A_PEND, 16'h0008);
      rd(A_PEND, d); check("R11 later clear", 32'(d), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule